// File: doc/BRIEF.md
# Multiplexed Display Bit-Plane Sequencer

Every display RAM word holds four bits, one per bit plane. This block decides which plane is sent to the display latch during each backplane step of the multiplex cycle. The number of active planes depends on the drive mode: one plane for static drive, two for 1:2, three for 1:3 and four for 1:4. A step strobe from the backplane timing moves the sequence forward. A sync input, or any change of mode, puts the sequence at its defined starting point. That starting point is the last active plane, so the next step begins a frame on plane 0.

In the static and 1:2 modes, a bank-select input moves the displayed planes up by two. Software can fill planes 2 and 3 while planes 0 and 1 are on screen, then swap the two banks. A new bank value is only taken at the step that starts a frame, so no frame ever mixes the two banks. The block drives two outputs: the physical plane index, and the logical backplane phase within the frame.

Top module: `bitplane_seq`

## Requirements
- R1: While `rst_n` is low, and until the first non-reset edge, `plane_o` and `phase_o` are both 0. The registered mode is static and the registered bank is 0.
- R2: The mode encoding is 3 for 1:4. In this mode, each step advances `phase_o` through 0, 1, 2, 3 and then back to 0. Outputs update on the clock edge that samples the step.
- R3: The mode encoding is 2 for 1:3. In this mode, each step advances `phase_o` through 0, 1, 2 and then back to 0.
- R4: The mode encoding is 1 for 1:2, where `phase_o` alternates 0, 1 on each step. The mode encoding is 0 for static, where `phase_o` stays 0.
- R5: A sampled `sync_i` sets `phase_o` to the last active phase of the current mode (3, 2, 1 or 0). Sync takes priority over a step in the same cycle.
- R6: A `mode_i` value that differs from the registered mode takes effect at the next edge. It resynchronises exactly as R5 does, and any step in that cycle is ignored.
- R7: In static mode with the registered bank at 1, `plane_o` is 2 instead of 0.
- R8: In 1:2 mode with the registered bank at 1, `plane_o` follows phase + 2, which gives planes 2 and 3.
- R9: In the 1:3 and 1:4 modes, `plane_o` equals `phase_o` whatever the bank value.
- R10: `bank_sel_i` is sampled into the registered bank only by a step that wraps the phase to 0. A change at any other time leaves `plane_o` unaffected until that wrap.
- R11: A cycle with no step, no sync and an unchanged mode leaves `plane_o` and `phase_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Drive mode: 0 static, 1 for 1:2, 2 for 1:3, 3 for 1:4 |
| step_i | input | 1 | Backplane step strobe, one step per sampled high cycle |
| sync_i | input | 1 | Resynchronise sequence to the last active phase |
| bank_sel_i | input | 1 | Requested display bank for static and 1:2 modes |
| plane_o | output | 2 | Selected bit-plane index for the display latch |
| phase_o | output | 2 | Logical backplane phase within the frame |

## Verification
The properties assume that every input is a synchronous level, sampled once per rising edge. A step or sync held high for several cycles therefore counts once per cycle. The properties also assume that all four mode encodings are legal, so no input combination is excluded. The stimulus changes inputs only on falling edges. It draws mode changes and syncs rarely enough that full frames run between them, while still hitting a step and a sync in the same cycle, and bank flips both in mid-frame and on the wrap step.

// File: rtl/bps_pkg.sv
package bps_pkg;

    localparam int NUM_PLANES = 4;
    localparam int PW         = $clog2(NUM_PLANES);
    localparam int BANK_SHIFT = NUM_PLANES / 2;

    localparam logic [PW-1:0] BANK_OFFSET = PW'(BANK_SHIFT);

    typedef enum logic [PW-1:0] {
        MODE_STATIC = 2'd0,
        MODE_DUAL   = 2'd1,
        MODE_TRI    = 2'd2,
        MODE_QUAD   = 2'd3
    } mux_mode_e;

    // Counter state: logical phase and the mode it is counting for
    typedef struct packed {
        logic [PW-1:0] phase;
        mux_mode_e     mode;
    } ctr_state_t;

    // Mapper state: latched bank and the physical plane presented
    typedef struct packed {
        logic          bank;
        logic [PW-1:0] plane;
    } map_state_t;

    // Last active phase of a mode equals its encoding
    function automatic logic [PW-1:0] last_phase(mux_mode_e m);
        return PW'(m);
    endfunction

    // Modes with an alternate bank
    function automatic logic is_banked(mux_mode_e m);
        return (m == MODE_STATIC) || (m == MODE_DUAL);
    endfunction

endpackage

// File: rtl/bps_phase_ctr.sv
module bps_phase_ctr
    import bps_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  mux_mode_e     mode_i,
    input  logic          step_i,
    input  logic          sync_i,
    output logic [PW-1:0] phase_q_o,
    output logic [PW-1:0] phase_d_o,
    output mux_mode_e     mode_q_o,
    output mux_mode_e     mode_d_o,
    output logic          frame_start_o
);

    ctr_state_t st_d, st_q;
    logic       resync;
    logic       at_last;

    always_comb begin
        st_d          = st_q;
        frame_start_o = 1'b0;
        resync        = sync_i || (mode_i != st_q.mode);
        at_last       = (st_q.phase == last_phase(st_q.mode));
        if (resync) begin
            st_d.mode  = mode_i;
            st_d.phase = last_phase(mode_i);
        end else if (step_i) begin
            if (at_last) begin
                st_d.phase    = '0;
                frame_start_o = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: '0, mode: MODE_STATIC};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q_o = st_q.phase;
    assign phase_d_o = st_d.phase;
    assign mode_q_o  = st_q.mode;
    assign mode_d_o  = st_d.mode;

endmodule

// File: rtl/bps_bank_map.sv
module bps_bank_map
    import bps_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start_i,
    input  logic          bank_sel_i,
    input  logic [PW-1:0] phase_d_i,
    input  mux_mode_e     mode_d_i,
    output logic [PW-1:0] plane_o,
    output logic          bank_o
);

    map_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bank = frame_start_i ? bank_sel_i : st_q.bank;
        if (is_banked(mode_d_i) && st_d.bank) begin
            st_d.plane = phase_d_i + BANK_OFFSET;
        end else begin
            st_d.plane = phase_d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bank: 1'b0, plane: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign plane_o = st_q.plane;
    assign bank_o  = st_q.bank;

endmodule

// File: rtl/bitplane_seq.sv
module bitplane_seq
    import bps_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          step_i,
    input  logic          sync_i,
    input  logic          bank_sel_i,
    output logic [1:0]    plane_o,
    output logic [1:0]    phase_o
);

    mux_mode_e     mode_q;
    mux_mode_e     mode_d;
    logic [PW-1:0] phase_d;
    logic          frame_start;
    logic          bank_q;

    bps_phase_ctr u_ctr (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mux_mode_e'(mode_i)),
        .step_i        (step_i),
        .sync_i        (sync_i),
        .phase_q_o     (phase_o),
        .phase_d_o     (phase_d),
        .mode_q_o      (mode_q),
        .mode_d_o      (mode_d),
        .frame_start_o (frame_start)
    );

    bps_bank_map u_map (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .bank_sel_i    (bank_sel_i),
        .phase_d_i     (phase_d),
        .mode_d_i      (mode_d),
        .plane_o       (plane_o),
        .bank_o        (bank_q)
    );

endmodule

// File: rtl/bps_checker.sv
module bps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       step_i,
    input logic       sync_i,
    input logic [1:0] plane_o,
    input logic [1:0] phase_o,
    input logic [1:0] mode_q,
    input logic       bank_q
);

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o <= mode_q); // R4

    AST_SYNC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (phase_o == $past(mode_i))); // R5

    AST_MODE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |=> (phase_o == $past(mode_i) && mode_q == $past(mode_i))); // R6

    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !sync_i && mode_i == mode_q && phase_o != mode_q)
        |=> (phase_o == $past(phase_o) + 2'd1)); // R2

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !sync_i && mode_i == mode_q && phase_o == mode_q)
        |=> (phase_o == 2'd0)); // R3

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !sync_i && mode_i == mode_q)
        |=> ($stable(phase_o) && $stable(plane_o))); // R11

    AST_UNBANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q >= 2'd2) |-> (plane_o == phase_o)); // R9

    AST_STATIC_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0) |-> (plane_o == {bank_q, 1'b0})); // R7

    AST_DUAL_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1 && bank_q) |-> plane_o[1]); // R8

    AST_BANK_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_q) |-> (phase_o == 2'd0)); // R10

endmodule

bind bitplane_seq bps_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .step_i  (step_i),
    .sync_i  (sync_i),
    .plane_o (plane_o),
    .phase_o (phase_o),
    .mode_q  (mode_q),
    .bank_q  (bank_q)
);

// File: tb/bitplane_seq_tb.sv
`timescale 1ns/1ps
module bitplane_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       step_i = 1'b0;
    logic       sync_i = 1'b0;
    logic       bank_sel_i = 1'b0;
    logic [1:0] plane_o;
    logic [1:0] phase_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [1:0] m_mode = 2'd0;
    logic [1:0] m_phase = 2'd0;
    logic       m_bank = 1'b0;

    always #2 clk = ~clk;

    bitplane_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .step_i     (step_i),
        .sync_i     (sync_i),
        .bank_sel_i (bank_sel_i),
        .plane_o    (plane_o),
        .phase_o    (phase_o)
    );

    function automatic logic [1:0] exp_plane(logic [1:0] md, logic [1:0] ph, logic bk);
        if (md <= 2'd1 && bk) return ph + 2'd2;
        return ph;
    endfunction

    task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(logic [1:0] m, logic st, logic sy, logic bk);
        string tag;
        @(negedge clk);
        mode_i = m; step_i = st; sync_i = sy; bank_sel_i = bk;
        if (sy)                                  tag = "R5";
        else if (m != m_mode)                    tag = "R6";
        else if (!st)                            tag = "R11";
        else if (m_phase == m_mode && bk != m_bank) tag = "R10";
        else if (m_bank && m_mode == 2'd0)       tag = "R7";
        else if (m_bank && m_mode == 2'd1)       tag = "R8";
        else if (bk && m_mode >= 2'd2)           tag = "R9";
        else if (m_mode == 2'd3)                 tag = "R2";
        else if (m_mode == 2'd2)                 tag = "R3";
        else                                     tag = "R4";
        @(posedge clk);
        if (sy || m != m_mode) begin
            m_mode  = m;
            m_phase = m;
        end else if (st) begin
            if (m_phase == m_mode) begin
                m_phase = 2'd0;
                m_bank  = bk;
            end else begin
                m_phase = m_phase + 2'd1;
            end
        end
        #1;
        check(tag, "phase", phase_o, m_phase);
        check(tag, "plane", plane_o, exp_plane(m_mode, m_phase, m_bank));
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [1:0] rm;
        logic rb;
        seed = 32'h5eed;
        void'($urandom(seed));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "phase", phase_o, 2'd0);
        check("R1", "plane", plane_o, 2'd0);
        rst_n = 1'b1;
        cyc(2'd0, 1'b0, 1'b0, 1'b0);

        // R2: 1:4 sequence via mode change (R6)
        cyc(2'd3, 1'b1, 1'b0, 1'b0);
        repeat (6) cyc(2'd3, 1'b1, 1'b0, 1'b0);
        // R5: sync mid-sequence with simultaneous step
        cyc(2'd3, 1'b1, 1'b1, 1'b0);
        repeat (2) cyc(2'd3, 1'b1, 1'b0, 1'b0);
        // R9: bank ignored in 1:4
        repeat (5) cyc(2'd3, 1'b1, 1'b0, 1'b1);
        // R3: 1:3 sequence
        cyc(2'd2, 1'b0, 1'b0, 1'b0);
        repeat (7) cyc(2'd2, 1'b1, 1'b0, 1'b1);
        // R4: 1:2 and static
        cyc(2'd1, 1'b1, 1'b0, 1'b0);
        repeat (5) cyc(2'd1, 1'b1, 1'b0, 1'b0);
        // R10, R8: bank raised in mid-frame, taken on wrap
        cyc(2'd1, 1'b1, 1'b0, 1'b1);
        cyc(2'd1, 1'b1, 1'b0, 1'b1);
        repeat (4) cyc(2'd1, 1'b1, 1'b0, 1'b1);
        // R11: idle cycles
        repeat (3) cyc(2'd1, 1'b0, 1'b0, 1'b0);
        // R7: static with bank
        cyc(2'd0, 1'b0, 1'b0, 1'b1);
        repeat (3) cyc(2'd0, 1'b1, 1'b0, 1'b1);
        cyc(2'd0, 1'b1, 1'b0, 1'b0);
        cyc(2'd0, 1'b0, 1'b1, 1'b1);

        // Constrained random
        rm = 2'd3;
        rb = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) rm = 2'($urandom_range(3));
            if ($urandom_range(7) == 0)  rb = ~rb;
            cyc(rm, 1'($urandom_range(1)), ($urandom_range(19) == 0), rb);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule